// File: doc/BRIEF.md
# Half-Duplex Link Master Controller

This block is the master end of a polled, half-duplex command link to one remote slave. After reset, or whenever the link is lost, it asks a control-byte transmitter for a link-reset command. It repeats that request at a fixed retry period until the receiver reports an IDLE answer from the slave. Once the link is up, the controller works in slots that alternate between a send opportunity and a poll. A poll is a read request, and the slave answers with "no data", with the start of a packet, or with a reboot notice. A send is granted through a packet-send enable to a separate packet framer, and the slave then answers with a buffer acknowledgement. While the slave reports no free buffer, send slots carry buffer-status queries instead of packets.

The controller never handles bytes itself. It exchanges 4-bit command codes with a transmitter (valid/ready request) and a receiver (one-cycle valid strobe). It gives the upper logic a one-cycle message-received pulse and a one-cycle error pulse. Any reply that does not arrive within a reply timeout counts as a lost slave and sends the controller back to the reset loop. Packets are never retransmitted automatically: when the slave acknowledges with an error, the upper logic is informed and decides what to do.

Top module: `link_master_ctrl`

## Requirements
- R1: While reset is asserted and during the two synchronizer cycles after release, `tx_cmd_vld`, `link_up`, `pkt_send_en`, `msg_irq` and `err_pulse` are 0. Afterwards the controller requests the link-reset code 4'b1011 with `link_up` still 0.
- R2: While the link is down and no IDLE arrives, consecutive accepted link-reset requests are exactly `RETRY_CYCLES` clock cycles apart when `tx_cmd_rdy` is held high.
- R3: An IDLE code (4'b1111) received while waiting in the reset loop sets `link_up` in the next cycle. At that point the slave is taken to have buffer space and the next dispatch slot is a send slot.
- R4: Dispatch slots alternate send, poll, send, and so on. In a send slot with `pkt_pending` high and buffer space known, `pkt_send_en` is raised. With `pkt_pending` high and no buffer, a buffer-status query 4'b1100 is requested. Otherwise, and in every poll slot, a read request 4'b0101 is requested.
- R5: After a read request, no-data 4'b0110 ends the exchange. Start-of-frame 4'b0001 opens a reception that ends at end-of-frame 4'b0010, and `msg_irq` is then high for exactly one cycle, in the cycle after the end-of-frame code.
- R6: `pkt_send_en` stays high until `pkt_sent` pulses. The reply 4'b1000 marks buffer space available and 4'b1001 marks no buffer. The reply 4'b1010 raises `err_pulse` for exactly one cycle, leaves the buffer state unchanged, and causes no automatic resend.
- R7: While no buffer is known, send slots with a pending packet keep issuing buffer-status queries. A 4'b1001 answer keeps the state, and only a 4'b1000 answer allows the next packet grant.
- R8: A reboot notice 4'b0111 answering a read request drops `link_up` in the next cycle, and the controller returns to requesting link-reset codes.
- R9: If a request is accepted (or `pkt_sent` seen, or a reception opened) in cycle t and no valid reply arrives, `link_up` falls and a link-reset request appears in cycle t+`REPLY_TIMEOUT`. A reply in cycle t+`REPLY_TIMEOUT`-1 is still honoured.
- R10: Codes that are not a valid answer in the current state, such as IDLE while the link is up or a buffer acknowledgement during a reception, are ignored: they change neither `link_up` nor the outputs, and the exchange continues.
- R11: While `tx_cmd_vld` is high and `tx_cmd_rdy` is low, `tx_cmd_vld` stays high and `tx_cmd` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_cmd_vld | output | 1 | Command request to the control-byte transmitter |
| tx_cmd | output | 4 | Command code requested |
| tx_cmd_rdy | input | 1 | Transmitter takes the command in this cycle |
| rx_cmd_vld | input | 1 | Receiver delivers a decoded command code this cycle |
| rx_cmd | input | 4 | Decoded command code from the slave |
| pkt_pending | input | 1 | Upper logic holds an outgoing packet |
| pkt_send_en | output | 1 | Grant to the packet framer to send one packet |
| pkt_sent | input | 1 | One-cycle pulse: framer finished the packet |
| link_up | output | 1 | Link synchronised with the slave |
| msg_irq | output | 1 | One-cycle pulse: complete packet received from the slave |
| err_pulse | output | 1 | One-cycle pulse: slave reported a packet received with error |

## Verification
The hardest case to reach is a reply that lands in the final cycle of the timeout window, one cycle before the controller would declare the slave lost. The stimulus counts falling edges from the acceptance of a read request, places the no-data answer in exactly that cycle, and checks that the link stays up. In a second pass it withholds the answer and checks that the link drops one cycle later. Flow-control corners, such as a full slave buffer followed by repeated no-buffer answers, come from seeded random replies. A bench model of the slot alternation and the buffer state predicts every dispatch.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic [3:0] {
    CMD_NONE     = 4'b0000,
    CMD_SOF      = 4'b0001,
    CMD_EOF      = 4'b0010,
    CMD_IDREQ    = 4'b0011,
    CMD_RDREQ    = 4'b0101,
    CMD_NODATA   = 4'b0110,
    CMD_REBOOT   = 4'b0111,
    CMD_ACK_BUF  = 4'b1000,
    CMD_ACK_FULL = 4'b1001,
    CMD_ACK_ERR  = 4'b1010,
    CMD_LINKRST  = 4'b1011,
    CMD_BUFQ     = 4'b1100,
    CMD_SOFTRST  = 4'b1101,
    CMD_TCAL     = 4'b1110,
    CMD_IDLE     = 4'b1111
  } lm_cmd_e;

  typedef enum logic [3:0] {
    ST_RST_TX,
    ST_RST_WAIT,
    ST_READY,
    ST_POLL_TX,
    ST_POLL_WAIT,
    ST_RX_PKT,
    ST_PKT_TX,
    ST_PKT_WAIT,
    ST_BUF_TX,
    ST_BUF_WAIT
  } lm_state_e;

  typedef struct packed {
    logic idle;
    logic sof;
    logic eof;
    logic nodata;
    logic reboot;
    logic ack_buf;
    logic ack_full;
    logic ack_err;
  } lm_reply_t;

endpackage

// File: rtl/lm_rst_sync.sv
module lm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/lm_reply_decode.sv
module lm_reply_decode
  import lm_pkg::*;
(
  input  logic       code_vld,
  input  logic [3:0] code,
  output lm_reply_t  reply
);
  always_comb begin
    reply          = '0;
    reply.idle     = code_vld && (code == CMD_IDLE);
    reply.sof      = code_vld && (code == CMD_SOF);
    reply.eof      = code_vld && (code == CMD_EOF);
    reply.nodata   = code_vld && (code == CMD_NODATA);
    reply.reboot   = code_vld && (code == CMD_REBOOT);
    reply.ack_buf  = code_vld && (code == CMD_ACK_BUF);
    reply.ack_full = code_vld && (code == CMD_ACK_FULL);
    reply.ack_err  = code_vld && (code == CMD_ACK_ERR);
  end
endmodule

// File: rtl/lm_tick_counter.sv
module lm_tick_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= CW'(1);
    else if (inc)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/link_master_ctrl.sv
module link_master_ctrl
  import lm_pkg::*;
#(
  parameter int RETRY_CYCLES  = 100000,
  parameter int REPLY_TIMEOUT = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tx_cmd_vld,
  output logic [3:0] tx_cmd,
  input  logic       tx_cmd_rdy,
  input  logic       rx_cmd_vld,
  input  logic [3:0] rx_cmd,
  input  logic       pkt_pending,
  output logic       pkt_send_en,
  input  logic       pkt_sent,
  output logic       link_up,
  output logic       msg_irq,
  output logic       err_pulse
);
  localparam int LIM = (RETRY_CYCLES > REPLY_TIMEOUT) ? RETRY_CYCLES : REPLY_TIMEOUT;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYCLES - 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(REPLY_TIMEOUT - 1);
  localparam logic [CW-1:0] CNT_MAX    = CW'(LIM);

  logic        rst_ok;
  lm_reply_t   rp;
  logic [CW-1:0] tmr;
  logic        tmr_load, tmr_inc;

  lm_state_e state_q, state_d;
  logic link_q, link_d;
  logic buf_q, buf_d;
  logic turn_q, turn_d;
  logic irq_q, irq_d;
  logic err_q, err_d;
  logic timeout;

  lm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  lm_reply_decode u_dec (.code_vld(rx_cmd_vld), .code(rx_cmd), .reply(rp));

  lm_tick_counter #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_ok), .load(tmr_load), .inc(tmr_inc), .cnt(tmr)
  );

  assign timeout = (tmr == TMO_LAST);

  // next-state process
  always_comb begin
    state_d  = state_q;
    link_d   = link_q;
    buf_d    = buf_q;
    turn_d   = turn_q;
    irq_d    = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_inc  = 1'b0;
    case (state_q)
      ST_RST_TX: begin
        if (tx_cmd_rdy) begin
          state_d  = ST_RST_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_RST_WAIT: begin
        tmr_inc = 1'b1;
        if (rp.idle) begin
          state_d = ST_READY;
          link_d  = 1'b1;
          buf_d   = 1'b1;
          turn_d  = 1'b0;
        end else if (tmr == RETRY_LAST) begin
          state_d = ST_RST_TX;
        end
      end
      ST_READY: begin
        turn_d = ~turn_q;
        if (!turn_q && pkt_pending && buf_q) state_d = ST_PKT_TX;
        else if (!turn_q && pkt_pending)     state_d = ST_BUF_TX;
        else                                 state_d = ST_POLL_TX;
      end
      ST_POLL_TX: begin
        if (tx_cmd_rdy) begin
          state_d  = ST_POLL_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_POLL_WAIT: begin
        tmr_inc = 1'b1;
        if (rp.nodata) begin
          state_d = ST_READY;
        end else if (rp.sof) begin
          state_d  = ST_RX_PKT;
          tmr_load = 1'b1;
        end else if (rp.reboot || timeout) begin
          state_d = ST_RST_TX;
          link_d  = 1'b0;
        end
      end
      ST_RX_PKT: begin
        tmr_inc = 1'b1;
        if (rp.eof) begin
          state_d = ST_READY;
          irq_d   = 1'b1;
        end else if (timeout) begin
          state_d = ST_RST_TX;
          link_d  = 1'b0;
        end
      end
      ST_PKT_TX: begin
        if (pkt_sent) begin
          state_d  = ST_PKT_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_PKT_WAIT: begin
        tmr_inc = 1'b1;
        if (rp.ack_buf) begin
          state_d = ST_READY;
          buf_d   = 1'b1;
        end else if (rp.ack_full) begin
          state_d = ST_READY;
          buf_d   = 1'b0;
        end else if (rp.ack_err) begin
          state_d = ST_READY;
          err_d   = 1'b1;
        end else if (timeout) begin
          state_d = ST_RST_TX;
          link_d  = 1'b0;
        end
      end
      ST_BUF_TX: begin
        if (tx_cmd_rdy) begin
          state_d  = ST_BUF_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_BUF_WAIT: begin
        tmr_inc = 1'b1;
        if (rp.ack_buf) begin
          state_d = ST_READY;
          buf_d   = 1'b1;
        end else if (rp.ack_full) begin
          state_d = ST_READY;
        end else if (timeout) begin
          state_d = ST_RST_TX;
          link_d  = 1'b0;
        end
      end
      default: begin
        state_d = ST_RST_TX;
        link_d  = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q <= ST_RST_TX;
      link_q  <= 1'b0;
      buf_q   <= 1'b0;
      turn_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      link_q  <= link_d;
      buf_q   <= buf_d;
      turn_q  <= turn_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  // outputs
  always_comb begin
    tx_cmd_vld = 1'b0;
    tx_cmd     = CMD_NONE;
    case (state_q)
      ST_RST_TX:  begin tx_cmd_vld = rst_ok; tx_cmd = CMD_LINKRST; end
      ST_POLL_TX: begin tx_cmd_vld = rst_ok; tx_cmd = CMD_RDREQ;   end
      ST_BUF_TX:  begin tx_cmd_vld = rst_ok; tx_cmd = CMD_BUFQ;    end
      default:    ;
    endcase
  end

  assign pkt_send_en = (state_q == ST_PKT_TX);
  assign link_up     = link_q;
  assign msg_irq     = irq_q;
  assign err_pulse   = err_q;

  // assertions
  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_cmd_vld && !tx_cmd_rdy) |=> (tx_cmd_vld && $stable(tx_cmd)));

  a_r4_grant_needs_buffer: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(pkt_send_en) |-> (buf_q && link_q));

  a_r8_down_only_linkrst: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_cmd_vld && !link_q) |-> (tx_cmd == CMD_LINKRST));

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_ok)
    msg_irq |=> !msg_irq);

  a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_ok)
    err_pulse |=> !err_pulse);

  a_r6_grant_held: assert property (@(posedge clk) disable iff (!rst_ok)
    (pkt_send_en && !pkt_sent) |=> pkt_send_en);

  a_r9_silent_poll_drops: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_POLL_WAIT && tmr == TMO_LAST && !rx_cmd_vld) |=> (tx_cmd_vld && !link_q));

  a_r2_timer_bounded: assert property (@(posedge clk) disable iff (!rst_ok)
    tmr <= CNT_MAX);

endmodule

// File: tb/tb_link_master_ctrl.sv
module tb_link_master_ctrl;
  localparam int RETRY = 40;
  localparam int TMO   = 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_cmd_vld;
  logic [3:0] tx_cmd;
  logic       tx_cmd_rdy;
  logic       rx_cmd_vld;
  logic [3:0] rx_cmd;
  logic       pkt_pending;
  logic       pkt_send_en;
  logic       pkt_sent;
  logic       link_up;
  logic       msg_irq;
  logic       err_pulse;

  always #10 clk = ~clk;

  link_master_ctrl #(.RETRY_CYCLES(RETRY), .REPLY_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .tx_cmd_vld(tx_cmd_vld), .tx_cmd(tx_cmd),
    .tx_cmd_rdy(tx_cmd_rdy), .rx_cmd_vld(rx_cmd_vld), .rx_cmd(rx_cmd),
    .pkt_pending(pkt_pending), .pkt_send_en(pkt_send_en), .pkt_sent(pkt_sent),
    .link_up(link_up), .msg_irq(msg_irq), .err_pulse(err_pulse)
  );

  int  vec = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  force_rdy = 1'b0;
  bit  m_turn, m_buf;

  localparam int K_POLL = 5, K_BUFQ = 12, K_SEND = 16, K_RST = 11;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_kind(input bit turn, input bit pend, input bit bufok);
    if (!turn && pend && bufok) return K_SEND;
    if (!turn && pend)          return K_BUFQ;
    return K_POLL;
  endfunction

  task automatic wait_req(output int kind);
    do @(negedge clk); while (!tx_cmd_vld && !pkt_send_en);
    kind = pkt_send_en ? K_SEND : int'(tx_cmd);
  endtask

  // called at a negedge with tx_cmd_vld high; returns just after the accepting edge
  task automatic accept_cmd(input int exp, input string req);
    logic [3:0] first;
    first = tx_cmd;
    chk(first == 4'(exp), req, first, exp);
    forever begin
      tx_cmd_rdy = force_rdy || (($urandom % 4) != 0);
      if (tx_cmd_rdy) begin
        @(posedge clk); #1 tx_cmd_rdy = 1'b0;
        break;
      end
      @(negedge clk);
      chk(tx_cmd_vld && tx_cmd == first, "R11", tx_cmd, first);
    end
  endtask

  task automatic reply(input logic [3:0] code, input bit nxt_pend);
    @(negedge clk); rx_cmd_vld = 1'b1; rx_cmd = code;
    @(negedge clk); rx_cmd_vld = 1'b0; pkt_pending = nxt_pend;
  endtask

  task automatic sync_link(input int retries, input bit nxt_pend);
    int k;
    for (int i = 0; i <= retries; i++) begin
      wait_req(k);
      accept_cmd(K_RST, "R8");
    end
    reply(4'b1111, nxt_pend);
    chk(link_up == 1'b1, "R3", link_up, 1);
    m_turn = 1'b0;
    m_buf  = 1'b1;
  endtask

  task automatic dispatch_check(output int kind);
    int e;
    e = exp_kind(m_turn, pkt_pending, m_buf);
    m_turn = ~m_turn;
    wait_req(kind);
    chk(kind == e, (e == K_BUFQ) ? "R7" : "R4", kind, e);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int k, n, r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tx_cmd_rdy = 1'b0; rx_cmd_vld = 1'b0; rx_cmd = 4'h0;
    pkt_pending = 1'b0; pkt_sent = 1'b0;
    repeat (4) @(negedge clk);
    chk(!tx_cmd_vld && !link_up && !pkt_send_en && !msg_irq && !err_pulse, "R1 in reset", tx_cmd_vld, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_cmd_vld && tx_cmd == 4'b1011, "R1 first request", tx_cmd, 4'b1011);
    chk(!link_up && !pkt_send_en && !msg_irq && !err_pulse, "R1 outputs", link_up, 0);

    // R2: retry interval
    force_rdy = 1'b1;
    accept_cmd(K_RST, "R2");
    n = 0;
    do begin @(negedge clk); n++; end while (!tx_cmd_vld && n < 5 * RETRY);
    chk(n == RETRY, "R2 retry period", n, RETRY);
    accept_cmd(K_RST, "R2");
    reply(4'b1111, 1'b0);
    chk(link_up == 1'b1, "R3 idle brings link up", link_up, 1);
    m_turn = 1'b0; m_buf = 1'b1;

    // R10: stray IDLE while up, then R9 edge: reply in last window cycle
    dispatch_check(k);
    accept_cmd(K_POLL, "R4");
    repeat (TMO - 2) @(negedge clk);
    chk(link_up && !tx_cmd_vld, "R9 before edge", link_up, 1);
    reply(4'b0110, 1'b0);
    chk(link_up == 1'b1, "R9 late reply honoured", link_up, 1);
    reply(4'b1111, 1'b0);
    chk(link_up == 1'b1, "R10 stray idle ignored", link_up, 1);

    // R9: silence after read request
    dispatch_check(k);
    accept_cmd(K_POLL, "R4");
    repeat (TMO - 1) @(negedge clk);
    chk(link_up && !tx_cmd_vld, "R9 last window cycle", link_up, 1);
    @(negedge clk);
    chk(!link_up && tx_cmd_vld && tx_cmd == 4'b1011, "R9 timeout drop", {link_up, tx_cmd}, 4'b1011);
    force_rdy = 1'b0;
    sync_link(1, 1'b1);

    // directed R7: no buffer, repeated full answers
    dispatch_check(k);
    @(negedge clk); pkt_sent = 1'b1; @(negedge clk); pkt_sent = 1'b0;
    chk(!pkt_send_en, "R6 grant released", pkt_send_en, 0);
    reply(4'b1001, 1'b1); m_buf = 1'b0;
    for (int i = 0; i < 3; i++) begin
      dispatch_check(k);
      if (k == K_POLL) begin accept_cmd(K_POLL, "R4"); reply(4'b0110, 1'b1); end
      else begin accept_cmd(K_BUFQ, "R7"); reply(4'b1001, 1'b1); end
    end

    // random phase
    for (int it = 0; it < 400; it++) begin
      bit np;
      np = ($urandom % 3) != 0;
      dispatch_check(k);
      if (k == K_SEND) begin
        n = $urandom % 3;
        repeat (n) begin @(negedge clk); chk(pkt_send_en, "R6 grant held", pkt_send_en, 1); end
        @(negedge clk); pkt_sent = 1'b1; @(negedge clk); pkt_sent = 1'b0;
        r = $urandom % 3;
        if (r == 0) begin reply(4'b1000, np); m_buf = 1'b1; chk(!err_pulse, "R6 no err", err_pulse, 0); end
        else if (r == 1) begin reply(4'b1001, np); m_buf = 1'b0; end
        else begin
          reply(4'b1010, np);
          chk(err_pulse, "R6 err pulse", err_pulse, 1);
          @(negedge clk);
          chk(!err_pulse && !pkt_send_en, "R6 err single, no resend", err_pulse, 0);
        end
      end else if (k == K_BUFQ) begin
        accept_cmd(K_BUFQ, "R7");
        if (($urandom % 2) == 0) begin reply(4'b1000, np); m_buf = 1'b1; end
        else reply(4'b1001, np);
      end else begin
        accept_cmd(K_POLL, "R4");
        r = $urandom % 10;
        if (r < 4) begin
          reply(4'b0110, np);
          chk(!msg_irq && link_up, "R5 no data", msg_irq, 0);
        end else if (r < 8) begin
          reply(4'b0001, np);
          if (r == 7) begin
            reply(4'b1000, np);
            chk(!msg_irq && link_up, "R10 stray ack in reception", msg_irq, 0);
          end
          reply(4'b0010, np);
          chk(msg_irq, "R5 irq on end of frame", msg_irq, 1);
          @(negedge clk);
          chk(!msg_irq, "R5 irq single cycle", msg_irq, 0);
        end else if (r == 8) begin
          reply(4'b0111, np);
          chk(!link_up && tx_cmd_vld && tx_cmd == 4'b1011, "R8 reboot drop", {link_up, tx_cmd}, 4'b1011);
          sync_link($urandom % 2, np);
        end else begin
          reply(4'b1001, np);
          chk(link_up && !err_pulse, "R10 stray ack in poll", link_up, 1);
          reply(4'b0110, np);
        end
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule